// File: doc/BRIEF.md
# PHY Control Register Bank with Per-Write Bit Masks

This block is a set of seven 16-bit control registers and one read-only status register for a storage-interface PHY. Each register sits on a simple word-addressed register bus. Software never has to read a register before changing part of it. Every write word carries its own mask in bits 31:16 and its data in bits 15:0. Only the register bits whose mask bit is 1 take the new data, and all other bits stay as they were.

The register contents drive the PHY's control fields directly as parallel outputs:

- tap-delay controls
- DLL frequency select
- pad pull, pull-up and open-drain controls
- power-up and DLL enable
- drive strength and charge-pump trim

Three PHY status inputs are resynchronised through two flops and then read from the status word: calibration done, DLL ready and a 4-bit resistor trim code. After reset every control register is zero, so the PHY is held powered down with its DLL off.

Top module: `phy_ctrl_bank`

## Requirements
- R1: A write of word W to a control register sets register bit i (0..15) to W[i] wherever W[16+i] is 1.
- R2: Register bits whose mask bit is 0 keep their value. A write with an all-zero mask changes nothing, and cycles with no write change nothing.
- R3: Control register k (k = 0..6) is written and read at byte offset 4*k (0x00 to 0x18). A write reaches only the addressed register.
- R4: A read of a control register returns its 16 stored bits in bits 15:0 and zero in bits 31:16. The read data is combinational on the address.
- R5: Writes to the status offset 0x20, to offset 0x1C, to offsets 0x24 to 0x3C, or to any offset with bits 1:0 not zero change no register.
- R6: After a synchronous active-low reset every control register and every control output is zero, which means phy_pwr_up = 0 and dll_en = 0.
- R7: Register 0 drives four output groups: itap_en from bit 0, itap_sel from bits 5:1 and itap_win from bit 6; otap_sel from bits 10:7 and otap_en from bit 11; and dll_freq_sel from bits 13:12, where 0 means 200 MHz, 1 means 50 MHz, 2 means 100 MHz and 3 means 150 MHz.
- R8: Register 6 drives phy_pwr_up from bit 0 (1 = powered), dll_en from bit 1, drv_type from bits 6:4 and dll_trim from bits 12:9.
- R9: Bits 9:0 of registers 2, 3, 4 and 5 drive pull_en, pull_up, od_release and od_en respectively. Within each, bits 7:0 are the data lines, bit 8 is the command line and bit 9 is the strobe.
- R10: A read of the status offset returns calibration done in bit 6, DLL ready in bit 5 and the resistor trim code in bits 4:1, with every other bit zero.
- R11: A status input that changes before rising edge k becomes visible in the status read after rising edge k+1, and not after edge k.
- R12: A read of an offset that is unmapped or misaligned returns zero.
- R13: All 16 bits of register 1 appear unchanged on aux_ctrl.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Byte offset within the bank |
| bus_wdata | input | 32 | Mask in 31:16, data in 15:0 |
| bus_rdata | output | 32 | Read data for bus_addr |
| cal_done_in | input | 1 | PHY calibration done (asynchronous) |
| dll_ready_in | input | 1 | PHY DLL ready (asynchronous) |
| rtrim_in | input | 4 | PHY resistor trim code (asynchronous) |
| dll_freq_sel | output | 2 | DLL frequency range select |
| otap_en | output | 1 | Output tap delay enable |
| otap_sel | output | 4 | Output tap select |
| itap_win | output | 1 | Input tap change window |
| itap_sel | output | 5 | Input tap select |
| itap_en | output | 1 | Input tap delay enable |
| aux_ctrl | output | 16 | Register 1 contents |
| pull_en | output | 10 | Pad pull enables |
| pull_up | output | 10 | Pad pull-up selects |
| od_release | output | 10 | Pad open-drain release |
| od_en | output | 10 | Pad open-drain enables |
| dll_trim | output | 4 | DLL charge-pump trim |
| drv_type | output | 3 | Pad drive strength type |
| dll_en | output | 1 | DLL enable |
| phy_pwr_up | output | 1 | PHY power-up, active high |

## Verification
A register bit that takes a value it should not shows up on its control output one cycle after the offending write edge. It also shows in the read data as soon as that offset is addressed. The bench keeps its own model of every register and compares all outputs on every clock, so a wrong update is caught on the cycle after the write that caused it. A wrong status pipeline depth shows as the status read changing one cycle early or one cycle late relative to the input. A wrong decode shows as an unmapped read returning something other than zero, or as a write landing in a neighbouring register.

// File: rtl/phyreg_pkg.sv
// Package: shared constants for the PHY control register bank.
// Assumes a 16-bit register payload and a 10-bit pad-control group.
package phyreg_pkg;
    localparam int REG_TAP     = 0;
    localparam int REG_AUX     = 1;
    localparam int REG_PULL_EN = 2;
    localparam int REG_PULL_UP = 3;
    localparam int REG_OD_REL  = 4;
    localparam int REG_OD_EN   = 5;
    localparam int REG_PWR     = 6;
    localparam int PAD_W       = 10;
    localparam int STAT_W      = 6;
endpackage

// File: rtl/phyreg_mask_reg.sv
// Module: one control register with a per-bit write mask.
// The upper W bits of wr_word are the mask and the lower W bits the data.
// Assumes wr_sel is already decoded for this register.
module phyreg_mask_reg #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_sel,
    input  logic [2*W-1:0] wr_word,
    output logic [W-1:0]   q
);
    logic [W-1:0] mask;
    logic [W-1:0] data;

    // Split the write word into its mask and data halves.
    assign mask = wr_word[2*W-1:W];
    assign data = wr_word[W-1:0];

    // Update only the bits whose mask bit is set; reset clears the register.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (wr_sel) q <= (q & ~mask) | (data & mask);
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(q));
    // R2
    masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> (((q ^ $past(q)) & ~$past(mask)) == '0));
    // R1
    enabled_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> (((q ^ $past(data)) & $past(mask)) == '0));
endmodule

// File: rtl/phyreg_sync.sv
// Module: a flop-chain synchroniser for a vector of slow status levels.
// Assumes each multi-bit input is held stable for several cycles.
module phyreg_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage [STAGES];
    logic [1:0]   age;

    // Shift the inputs through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= din;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign dout = stage[STAGES-1];

    // Count cycles since reset so the lag check only looks back over valid history.
    always_ff @(posedge clk) begin
        if (!rst_n)            age <= '0;
        else if (age != 2'd3)  age <= age + 2'd1;
    end

    generate
        if (STAGES == 2) begin : g_lag_chk
            // R11
            sync_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (age == 2'd3) |-> (dout == $past(din, 2)));
        end
    endgenerate
endmodule

// File: rtl/phyreg_rd_mux.sv
// Module: read-back selection for the register bank.
// Returns a control register, the status word, or zero for an unmapped or misaligned offset.
module phyreg_rd_mux #(
    parameter int REG_W    = 16,
    parameter int NUM_CTRL = 7,
    parameter int IDX_W    = 4,
    parameter int STAT_IDX = 8
) (
    input  logic [IDX_W-1:0]   idx,
    input  logic               aligned,
    input  logic [REG_W-1:0]   ctrl [NUM_CTRL],
    input  logic [REG_W-1:0]   status,
    output logic [2*REG_W-1:0] rdata
);
    // Pick the addressed word; upper half is always zero.
    always_comb begin
        rdata = '0;
        if (aligned) begin
            for (int i = 0; i < NUM_CTRL; i++)
                if (idx == IDX_W'(i)) rdata[REG_W-1:0] = ctrl[i];
            if (idx == IDX_W'(STAT_IDX)) rdata[REG_W-1:0] = status;
        end
    end
endmodule

// File: rtl/phy_ctrl_bank.sv
// Module: PHY control register bank, the top level.
// Seven masked-write control registers drive the PHY fields in parallel, and one
// read-only status word shows synchronised PHY status. Assumes single-cycle
// write strobes and byte offsets on bus_addr.
module phy_ctrl_bank
    import phyreg_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int REG_W    = 16,
    parameter int NUM_CTRL = 7,
    parameter int STAT_IDX = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [2*REG_W-1:0]   bus_wdata,
    output logic [2*REG_W-1:0]   bus_rdata,
    input  logic                 cal_done_in,
    input  logic                 dll_ready_in,
    input  logic [3:0]           rtrim_in,
    output logic [1:0]           dll_freq_sel,
    output logic                 otap_en,
    output logic [3:0]           otap_sel,
    output logic                 itap_win,
    output logic [4:0]           itap_sel,
    output logic                 itap_en,
    output logic [REG_W-1:0]     aux_ctrl,
    output logic [PAD_W-1:0]     pull_en,
    output logic [PAD_W-1:0]     pull_up,
    output logic [PAD_W-1:0]     od_release,
    output logic [PAD_W-1:0]     od_en,
    output logic [3:0]           dll_trim,
    output logic [2:0]           drv_type,
    output logic                 dll_en,
    output logic                 phy_pwr_up
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]    idx;
    logic                aligned;
    logic [NUM_CTRL-1:0] wr_sel;
    logic [REG_W-1:0]    ctrl_q [NUM_CTRL];
    logic [STAT_W-1:0]   stat_sync;
    logic [REG_W-1:0]    stat_word;

    // Turn the byte offset into a word index plus an alignment flag.
    assign idx     = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    // Raise the write select of the one register the offset addresses.
    always_comb begin
        for (int i = 0; i < NUM_CTRL; i++)
            wr_sel[i] = bus_wr && aligned && (idx == IDX_W'(i));
    end

    generate
        for (genvar g = 0; g < NUM_CTRL; g++) begin : g_reg
            phyreg_mask_reg #(.W(REG_W)) u_reg (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_sel  (wr_sel[g]),
                .wr_word (bus_wdata),
                .q       (ctrl_q[g])
            );
            // R5
            stat_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && idx == IDX_W'(STAT_IDX)) |=> $stable(ctrl_q[g]));
        end
    endgenerate

    phyreg_sync #(.W(STAT_W), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cal_done_in, dll_ready_in, rtrim_in}),
        .dout  (stat_sync)
    );

    // Place the synchronised status in bits 6:1 of the status word.
    assign stat_word = REG_W'({stat_sync, 1'b0});

    phyreg_rd_mux #(
        .REG_W    (REG_W),
        .NUM_CTRL (NUM_CTRL),
        .IDX_W    (IDX_W),
        .STAT_IDX (STAT_IDX)
    ) u_rd (
        .idx     (idx),
        .aligned (aligned),
        .ctrl    (ctrl_q),
        .status  (stat_word),
        .rdata   (bus_rdata)
    );

    // Spread the register fields onto the PHY control outputs.
    assign itap_en      = ctrl_q[REG_TAP][0];
    assign itap_sel     = ctrl_q[REG_TAP][5:1];
    assign itap_win     = ctrl_q[REG_TAP][6];
    assign otap_sel     = ctrl_q[REG_TAP][10:7];
    assign otap_en      = ctrl_q[REG_TAP][11];
    assign dll_freq_sel = ctrl_q[REG_TAP][13:12];
    assign aux_ctrl     = ctrl_q[REG_AUX];
    assign pull_en      = ctrl_q[REG_PULL_EN][PAD_W-1:0];
    assign pull_up      = ctrl_q[REG_PULL_UP][PAD_W-1:0];
    assign od_release   = ctrl_q[REG_OD_REL][PAD_W-1:0];
    assign od_en        = ctrl_q[REG_OD_EN][PAD_W-1:0];
    assign phy_pwr_up   = ctrl_q[REG_PWR][0];
    assign dll_en       = ctrl_q[REG_PWR][1];
    assign drv_type     = ctrl_q[REG_PWR][6:4];
    assign dll_trim     = ctrl_q[REG_PWR][12:9];

    // R6
    reset_powered_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!phy_pwr_up && !dll_en && aux_ctrl == '0));
    // R12
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == IDX_W'(NUM_CTRL) || idx > IDX_W'(STAT_IDX)) |-> (bus_rdata == '0));
    // R4
    upper_half_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[2*REG_W-1:REG_W] == '0);
endmodule

// File: tb/phy_ctrl_bank_test.sv
// Bench: behavioural register model compared against the bank on every clock.
module phy_ctrl_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cal_done_in = 1'b0;
    logic        dll_ready_in = 1'b0;
    logic [3:0]  rtrim_in = '0;
    logic [1:0]  dll_freq_sel;
    logic        otap_en, itap_win, itap_en, dll_en, phy_pwr_up;
    logic [3:0]  otap_sel, dll_trim;
    logic [4:0]  itap_sel;
    logic [2:0]  drv_type;
    logic [15:0] aux_ctrl;
    logic [9:0]  pull_en, pull_up, od_release, od_en;

    int vectors = 0;
    int fails   = 0;
    bit finished = 0;

    // Model state
    bit [15:0] m_reg [7];
    bit [5:0]  m_hist [$];
    bit [5:0]  m_vis;

    always #2.5 clk = ~clk;

    phy_ctrl_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cal_done_in(cal_done_in), .dll_ready_in(dll_ready_in), .rtrim_in(rtrim_in),
        .dll_freq_sel(dll_freq_sel), .otap_en(otap_en), .otap_sel(otap_sel),
        .itap_win(itap_win), .itap_sel(itap_sel), .itap_en(itap_en),
        .aux_ctrl(aux_ctrl), .pull_en(pull_en), .pull_up(pull_up),
        .od_release(od_release), .od_en(od_en), .dll_trim(dll_trim),
        .drv_type(drv_type), .dll_en(dll_en), .phy_pwr_up(phy_pwr_up)
    );

    // Model update at every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 7; i++) m_reg[i] = '0;
            m_hist = '{6'd0};
            m_vis  = '0;
        end else begin
            if (bus_wr && bus_addr[1:0] == 2'b00 && bus_addr[5:2] < 4'd7)
                m_reg[bus_addr[5:2]] = (m_reg[bus_addr[5:2]] & ~bus_wdata[31:16])
                                     | (bus_wdata[15:0] & bus_wdata[31:16]);
            m_hist.push_back({cal_done_in, dll_ready_in, rtrim_in});
            m_vis = m_hist.pop_front();
        end
    end

    function automatic bit [31:0] exp_read(input bit [5:0] a);
        if (a[1:0] != 2'b00) return '0;
        if (a[5:2] < 4'd7)   return {16'd0, m_reg[a[5:2]]};
        if (a[5:2] == 4'd8)  return {25'd0, m_vis, 1'b0};
        return '0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output against the model.
    task automatic compare_all();
        string rtag;
        if (bus_addr[1:0] != 0 || bus_addr[5:2] == 4'd7 || bus_addr[5:2] > 4'd8) rtag = "R12 unmapped read";
        else if (bus_addr[5:2] == 4'd8) rtag = "R10 status read";
        else rtag = "R4 control read";
        chk(rtag, bus_rdata, exp_read(bus_addr));
        chk("R7 itap_en",      32'(itap_en),      32'(m_reg[0][0]));
        chk("R7 itap_sel",     32'(itap_sel),     32'(m_reg[0][5:1]));
        chk("R7 itap_win",     32'(itap_win),     32'(m_reg[0][6]));
        chk("R7 otap_sel",     32'(otap_sel),     32'(m_reg[0][10:7]));
        chk("R7 otap_en",      32'(otap_en),      32'(m_reg[0][11]));
        chk("R7 dll_freq_sel", 32'(dll_freq_sel), 32'(m_reg[0][13:12]));
        chk("R13 aux_ctrl",    32'(aux_ctrl),     32'(m_reg[1]));
        chk("R9 pull_en",      32'(pull_en),      32'(m_reg[2][9:0]));
        chk("R9 pull_up",      32'(pull_up),      32'(m_reg[3][9:0]));
        chk("R9 od_release",   32'(od_release),   32'(m_reg[4][9:0]));
        chk("R9 od_en",        32'(od_en),        32'(m_reg[5][9:0]));
        chk("R8 phy_pwr_up",   32'(phy_pwr_up),   32'(m_reg[6][0]));
        chk("R8 dll_en",       32'(dll_en),       32'(m_reg[6][1]));
        chk("R8 drv_type",     32'(drv_type),     32'(m_reg[6][6:4]));
        chk("R8 dll_trim",     32'(dll_trim),     32'(m_reg[6][12:9]));
    endtask

    // One bus cycle: drive at the falling edge, compare at the next falling edge.
    task automatic tick(input bit wr, input bit [5:0] a, input bit [31:0] d);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick(0, 6'h18, 0);
        // R6: everything zero after reset
        chk("R6 reg6 after reset", bus_rdata, 32'd0);
        chk("R6 phy_pwr_up", 32'(phy_pwr_up), 0);
        chk("R6 dll_en", 32'(dll_en), 0);
        // R1: full mask write
        tick(1, 6'h00, 32'hFFFF_A5A5);
        chk("R1 full write", bus_rdata, 32'h0000_A5A5);
        // R2: partial mask clears only the low byte
        tick(1, 6'h00, 32'h00FF_0000);
        chk("R2 partial mask", bus_rdata, 32'h0000_A500);
        tick(1, 6'h00, 32'h0000_FFFF);
        chk("R2 zero mask", bus_rdata, 32'h0000_A500);
        // R3: distinct value in each register, then read all back
        for (int k = 0; k < 7; k++) tick(1, 6'(4*k), {16'hFFFF, 16'(16'h1111 * (k+1))});
        for (int k = 0; k < 7; k++) begin
            tick(0, 6'(4*k), 0);
            chk("R3 readback", bus_rdata, {16'd0, 16'(16'h1111 * (k+1))});
        end
        // R5: writes to status, gap, top and misaligned offsets are ignored
        tick(1, 6'h20, 32'hFFFF_FFFF);
        tick(1, 6'h1C, 32'hFFFF_FFFF);
        tick(1, 6'h3C, 32'hFFFF_FFFF);
        tick(1, 6'h01, 32'hFFFF_FFFF);
        tick(1, 6'h1A, 32'hFFFF_FFFF);
        for (int k = 0; k < 7; k++) begin
            tick(0, 6'(4*k), 0);
            chk("R5 ignored write", bus_rdata, {16'd0, 16'(16'h1111 * (k+1))});
        end
        // R11: two-edge status latency
        cal_done_in = 1'b1; rtrim_in = 4'hA;
        tick(0, 6'h20, 0);
        chk("R11 after one edge", bus_rdata, 32'd0);
        tick(0, 6'h20, 0);
        chk("R11 after two edges", bus_rdata, 32'h0000_0054);
        dll_ready_in = 1'b1;
        tick(0, 6'h20, 0);
        tick(0, 6'h20, 0);
        chk("R10 status layout", bus_rdata, 32'h0000_0074);
        // R12: unmapped reads
        tick(0, 6'h1C, 0);
        chk("R12 gap read", bus_rdata, 32'd0);
        tick(0, 6'h2C, 0);
        chk("R12 high read", bus_rdata, 32'd0);
        // Random traffic with slowly varying status
        for (int n = 0; n < 600; n++) begin
            if (n % 8 == 0) begin
                cal_done_in  = 1'($urandom);
                dll_ready_in = 1'($urandom);
                rtrim_in     = 4'($urandom);
            end
            tick(($urandom % 10) < 6, 6'($urandom), $urandom);
        end
        // R6: reset in mid-run returns to zero
        rst_n = 1'b0;
        tick(0, 6'h18, 0);
        rst_n = 1'b1;
        tick(0, 6'h18, 0);
        chk("R6 reset mid-run", bus_rdata, 32'd0);
        chk("R6 pwr after reset", 32'(phy_pwr_up), 0);
        summary();
    end
endmodule